// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a 16-bit accumulator processor with a fixed set of sixteen operations. It fetches instruction words from a synchronous program memory that holds both code and data, and it reaches a separate 16-bit input/output memory only indirectly. The indirect word is a program-memory word that holds the I/O address. The core holds an accumulator, a carry flag, a program counter and a small hardware return stack. An arithmetic unit, a control-flow unit and the return stack are separate instances under the top.

Operations that touch memory take two clocks: an address phase and a data phase. The data phase also issues the next fetch. Branches, calls and returns take one clock, because the new fetch address goes straight to the memory. The block has no streaming interface. The only back-pressure is a global clock-enable. While it is low, every register in the core holds its value, and the surrounding memories must be gated by the same enable. A slow peripheral stalls the core by pulling this enable low until its data is ready.

Top module: `acc_core`

## Requirements
- R1: During and after reset the core presents program address 0, and its program-write, I/O-read and I/O-write strobes are low.
- R2: An instruction word carries the opcode in bits 15:12 and a program-memory operand address in bits 11:0, of which the low PAW bits are used. The opcode values are 0 load, 1 store, 2 add, 3 sub, 4 or, 5 and, 6 xor, 7 rotate-right, 8 byte-swap, 9 in, A out, B branch, C branch-if-carry-clear, D branch-if-nonzero, E call and F return.
- R3: Load copies the addressed word into the accumulator. Store writes the accumulator to the addressed word, and it is the only operation that raises the program-write strobe.
- R4: Add sets {carry, A} to M + A, and sub sets {carry, A} to M - A, each as a 17-bit result. The carry is not an input to either.
- R5: Or, and, xor and byte-swap (A = {M[7:0], M[15:8]}) write the accumulator and leave the carry unchanged.
- R6: Rotate-right sets A to {carry, M[15:1]} and sets the carry to M[0].
- R7: In and out read the program word at the operand address and use it as the 16-bit I/O address. In loads that I/O word into A, and out writes A to it.
- R8: The unconditional branch is always taken. Branch-if-carry-clear is taken only when the carry is 0, and branch-if-nonzero only when A is not 0.
- R9: Call pushes the address after the call and jumps to the operand address. Return pops the stack and ignores its operand bits.
- R10: A push onto a full stack overwrites the oldest entry. A pop from an empty stack yields address 0.
- R11: Opcodes 0 to A take two enabled clocks, and opcodes B to F take one.
- R12: Each program-write, I/O-read and I/O-write strobe lasts exactly one enabled clock.
- R13: While the clock-enable is low, no core state and no core output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Global clock-enable; low freezes the core |
| pm_addr | output | PAW | Program memory address |
| pm_rdata | input | 16 | Program memory read data, one enabled clock after the address |
| pm_wdata | output | 16 | Program memory write data (the accumulator) |
| pm_we | output | 1 | Program memory write strobe |
| io_addr | output | 16 | I/O memory address |
| io_rdata | input | 16 | I/O read data, sampled while io_rd is high |
| io_wdata | output | 16 | I/O write data (the accumulator) |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The properties assume that the program memory returns the word addressed on the previous enabled edge, and that it and the I/O memory obey the same clock-enable as the core. Under that assumption a frozen core sees a frozen read bus. The bench models both memories that way and changes the enable only away from the clock edge. It runs a first pass with the enable held high, so that the gaps between writes can be measured, and a second pass with a pseudo-random enable. The program's own return through an empty stack restarts it at address 0, which drives the second pass.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 4;
  localparam int OPND_W = 12;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 4'h0, OP_STORE = 4'h1, OP_ADD  = 4'h2, OP_SUB  = 4'h3,
    OP_OR    = 4'h4, OP_AND   = 4'h5, OP_XOR  = 4'h6, OP_ROR  = 4'h7,
    OP_SWAP  = 4'h8, OP_IN    = 4'h9, OP_OUT  = 4'hA, OP_BR   = 4'hB,
    OP_BNC   = 4'hC, OP_BNZ   = 4'hD, OP_CALL = 4'hE, OP_RET  = 4'hF
  } opcode_t;

  typedef enum logic [1:0] {PH_BOOT, PH_EXEC, PH_DATA} phase_t;

  // single-cycle control-flow group: B..F
  function automatic logic is_flow(opcode_t op);
    return (op == OP_BR) || (op[3:2] == 2'b11);
  endfunction

  function automatic logic writes_carry(opcode_t op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ROR);
  endfunction

  function automatic logic writes_acc(opcode_t op);
    return !is_flow(op) && (op != OP_STORE) && (op != OP_OUT);
  endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_t        op,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   mem_i,
  input  logic           c_i,
  output logic [W-1:0]   res_o,
  output logic           c_o
);
  localparam int HALF = W / 2;

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  assign sum_w = {1'b0, mem_i} + {1'b0, acc_i};
  assign dif_w = {1'b0, mem_i} - {1'b0, acc_i};

  always_comb begin
    res_o = mem_i;
    c_o   = c_i;
    case (op)
      OP_ADD:  {c_o, res_o} = sum_w;
      OP_SUB:  {c_o, res_o} = dif_w;
      OP_OR:   res_o = mem_i | acc_i;
      OP_AND:  res_o = mem_i & acc_i;
      OP_XOR:  res_o = mem_i ^ acc_i;
      OP_ROR: begin
        res_o = {c_i, mem_i[W-1:1]};
        c_o   = mem_i[0];
      end
      OP_SWAP: res_o = {mem_i[HALF-1:0], mem_i[W-1:HALF]};
      default: res_o = mem_i;
    endcase
  end
endmodule

// File: rtl/acc_flow.sv
module acc_flow
  import acc_pkg::*;
#(
  parameter int AW = 12
) (
  input  opcode_t        op,
  input  logic [AW-1:0]  target_i,
  input  logic [AW-1:0]  pc_inc_i,
  input  logic           acc_zero_i,
  input  logic           carry_i,
  input  logic [AW-1:0]  stack_top_i,
  output logic [AW-1:0]  next_o,
  output logic           push_o,
  output logic           pop_o
);
  always_comb begin
    next_o = pc_inc_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    case (op)
      OP_BR:   next_o = target_i;
      OP_BNC:  next_o = carry_i ? pc_inc_i : target_i;
      OP_BNZ:  next_o = acc_zero_i ? pc_inc_i : target_i;
      OP_CALL: begin
        next_o = target_i;
        push_o = 1'b1;
      end
      OP_RET: begin
        next_o = stack_top_i;
        pop_o  = 1'b1;
      end
      default: next_o = pc_inc_i;
    endcase
  end
endmodule

// File: rtl/acc_retstack.sv
module acc_retstack #(
  parameter int DEPTH = 4,
  parameter int AW    = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_i,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  push_addr_i,
  output logic [AW-1:0]  top_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_nxt, last_idx;
  logic [CW-1:0] cnt_q;

  assign wp_nxt   = (wp_q == LAST_SLOT) ? '0 : wp_q + 1'b1;
  assign last_idx = (wp_q == '0) ? LAST_SLOT : wp_q - 1'b1;
  assign top_o    = (cnt_q == '0) ? '0 : slot_q[last_idx];

  // circular storage: a push on a full stack lands on the oldest slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[i] <= '0;
      else if (ce_i && push_i && wp_q == PW'(i))    slot_q[i] <= push_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (ce_i) begin
      if (push_i) begin
        wp_q  <= wp_nxt;
        cnt_q <= (cnt_q == FULL_CNT) ? cnt_q : cnt_q + 1'b1;
      end else if (pop_i && cnt_q != '0) begin
        wp_q  <= last_idx;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R10
  stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R9
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && push_i) |=> (top_o == $past(push_addr_i)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int PAW         = 12,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  output logic [PAW-1:0]    pm_addr,
  input  logic [15:0]       pm_rdata,
  output logic [15:0]       pm_wdata,
  output logic              pm_we,
  output logic [15:0]       io_addr,
  input  logic [15:0]       io_rdata,
  output logic [15:0]       io_wdata,
  output logic              io_rd,
  output logic              io_wr
);
  phase_t            ph_q;
  logic [PAW-1:0]    pc_q, pc_inc, cur_x, flow_next, stk_top;
  logic [WORD_W-1:0] acc_q, alu_res;
  logic              cy_q, alu_cy, fl_push, fl_pop, flow_now;
  opcode_t           op_q, cur_op;

  // in the execute phase the read bus carries the instruction word
  assign cur_op   = opcode_t'(pm_rdata[WORD_W-1 -: OPC_W]);
  assign cur_x    = pm_rdata[PAW-1:0];
  assign pc_inc   = pc_q + 1'b1;
  assign flow_now = (ph_q == PH_EXEC) && is_flow(cur_op);

  acc_alu #(.W(WORD_W)) u_alu (
    .op    (op_q),
    .acc_i (acc_q),
    .mem_i (pm_rdata),
    .c_i   (cy_q),
    .res_o (alu_res),
    .c_o   (alu_cy)
  );

  acc_flow #(.AW(PAW)) u_flow (
    .op          (cur_op),
    .target_i    (cur_x),
    .pc_inc_i    (pc_inc),
    .acc_zero_i  (acc_q == '0),
    .carry_i     (cy_q),
    .stack_top_i (stk_top),
    .next_o      (flow_next),
    .push_o      (fl_push),
    .pop_o       (fl_pop)
  );

  acc_retstack #(.DEPTH(STACK_DEPTH), .AW(PAW)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_i        (ce),
    .push_i      (flow_now && fl_push),
    .pop_i       (flow_now && fl_pop),
    .push_addr_i (pc_inc),
    .top_o       (stk_top)
  );

  assign pm_wdata = acc_q;
  assign io_wdata = acc_q;

  always_comb begin
    pm_addr = pc_q;
    pm_we   = 1'b0;
    io_addr = '0;
    io_rd   = 1'b0;
    io_wr   = 1'b0;
    case (ph_q)
      PH_EXEC: begin
        if (is_flow(cur_op)) begin
          pm_addr = flow_next;
        end else begin
          pm_addr = cur_x;
          pm_we   = (cur_op == OP_STORE);
        end
      end
      PH_DATA: begin
        pm_addr = pc_inc;
        io_addr = pm_rdata;
        io_rd   = (op_q == OP_IN);
        io_wr   = (op_q == OP_OUT);
      end
      default: pm_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_BOOT;
      pc_q  <= '0;
      acc_q <= '0;
      cy_q  <= 1'b0;
      op_q  <= OP_LOAD;
    end else if (ce) begin
      case (ph_q)
        PH_BOOT: ph_q <= PH_EXEC;
        PH_EXEC: begin
          if (is_flow(cur_op)) begin
            pc_q <= flow_next;
          end else begin
            op_q <= cur_op;
            ph_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          pc_q <= pc_inc;
          ph_q <= PH_EXEC;
          if (op_q == OP_IN)          acc_q <= io_rdata;
          else if (writes_acc(op_q))  acc_q <= alu_res;
          if (writes_carry(op_q))     cy_q  <= alu_cy;
        end
        default: ph_q <= PH_BOOT;
      endcase
    end
  end

  // R12
  pm_we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pm_we) |=> !pm_we);

  // R12
  io_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && (io_rd || io_wr)) |=> !(io_rd || io_wr));

  // R13
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(pc_q) && $stable(acc_q) && $stable(cy_q) && $stable(ph_q)));

  // R11
  store_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pm_we) |=> (pm_addr == $past(pc_inc)));

  // R3
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pm_we) |=> $stable(acc_q));
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam int PAW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b1;
  logic [PAW-1:0] pm_addr;
  logic [15:0] pm_rdata = 16'h0;
  logic [15:0] pm_wdata, io_addr, io_rdata, io_wdata;
  logic        pm_we, io_rd, io_wr;

  always #10 clk = ~clk;

  acc_core #(.PAW(PAW), .STACK_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata), .pm_wdata(pm_wdata), .pm_we(pm_we),
    .io_addr(io_addr), .io_rdata(io_rdata), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  logic [15:0] pmem [256];
  logic [15:0] iomem [256];

  always @(posedge clk) if (ce) begin
    if (pm_we) pmem[pm_addr] <= pm_wdata;
    pm_rdata <= pmem[pm_addr];
  end
  always @(posedge clk) if (ce && io_wr) iomem[io_addr[7:0]] <= io_wdata;
  assign io_rdata = iomem[io_addr[7:0]];

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    int          gap;
    string       req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, items_seen = 0, since = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic [15:0] a, input logic [15:0] d,
                            input int gap, input string req);
    item_t it;
    it.addr = a; it.data = d; it.gap = gap; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) begin pmem[i] = 16'h0; iomem[i] = 16'h0; end
    iomem[8'h20] = 16'hBEEF;
    pmem[8'h00] = 16'h0080; pmem[8'h01] = 16'hA085; pmem[8'h02] = 16'h2081;
    pmem[8'h03] = 16'hA086; pmem[8'h04] = 16'h2083; pmem[8'h05] = 16'hC0F0;
    pmem[8'h06] = 16'hA087; pmem[8'h07] = 16'h3082; pmem[8'h08] = 16'hA088;
    pmem[8'h09] = 16'h7082; pmem[8'h0A] = 16'hA089; pmem[8'h0B] = 16'h8080;
    pmem[8'h0C] = 16'h6081; pmem[8'h0D] = 16'h4080; pmem[8'h0E] = 16'hA08A;
    pmem[8'h0F] = 16'h5081; pmem[8'h10] = 16'hA08B; pmem[8'h11] = 16'h1084;
    pmem[8'h12] = 16'hC0F0; pmem[8'h13] = 16'h0084; pmem[8'h14] = 16'hA08C;
    pmem[8'h15] = 16'h9091; pmem[8'h16] = 16'hA08D; pmem[8'h17] = 16'hE040;
    pmem[8'h18] = 16'hA08E; pmem[8'h19] = 16'h2083; pmem[8'h1A] = 16'hD019;
    pmem[8'h1B] = 16'hA08F; pmem[8'h1C] = 16'h2084; pmem[8'h1D] = 16'hC01F;
    pmem[8'h1E] = 16'h0083; pmem[8'h1F] = 16'hA090; pmem[8'h20] = 16'hA093;
    pmem[8'h21] = 16'h0084; pmem[8'h22] = 16'hA094; pmem[8'h23] = 16'hB024;
    pmem[8'h24] = 16'hA095; pmem[8'h25] = 16'hE060; pmem[8'h26] = 16'hA085;
    pmem[8'h40] = 16'h0092; pmem[8'h41] = 16'hF0F0;
    pmem[8'h60] = 16'hE062; pmem[8'h61] = 16'hF000; pmem[8'h62] = 16'hE064;
    pmem[8'h63] = 16'hF000; pmem[8'h64] = 16'hE066; pmem[8'h65] = 16'hF000;
    pmem[8'h66] = 16'hE068; pmem[8'h67] = 16'hF000; pmem[8'h68] = 16'h0092;
    pmem[8'h69] = 16'hF000;
    pmem[8'hF0] = 16'h0083; pmem[8'hF1] = 16'hA085; pmem[8'hF2] = 16'hB0F2;
    pmem[8'h80] = 16'h1234; pmem[8'h81] = 16'h00FF; pmem[8'h82] = 16'h0001;
    pmem[8'h83] = 16'hFFFF; pmem[8'h84] = 16'h0000;
    for (int k = 0; k < 12; k++) pmem[8'h85 + k] = 16'h0010 + 16'(k);
    pmem[8'h91] = 16'h0020; pmem[8'h92] = 16'h0003; pmem[8'h93] = 16'h001C;
    pmem[8'h94] = 16'h001D; pmem[8'h95] = 16'h001E;
  endtask

  task automatic push_pass();
    expect_out(16'h10, 16'h1234, 0, "R3 load/out");
    expect_out(16'h11, 16'h1333, 0, "R4 add");
    expect_out(16'h12, 16'h1332, 0, "R4 add carry, R8 bnc not taken");
    expect_out(16'h13, 16'hECCF, 0, "R4 sub");
    expect_out(16'h14, 16'h8000, 0, "R6 ror");
    expect_out(16'h15, 16'h36FD, 0, "R5 swap/xor/or");
    expect_out(16'h16, 16'h00FD, 0, "R5 and");
    expect_out(16'h17, 16'h00FD, 0, "R3 store/load, R5 carry kept");
    expect_out(16'h18, 16'hBEEF, 0, "R7 in indirect");
    expect_out(16'h19, 16'h0003, 0, "R9 call/return");
    expect_out(16'h1A, 16'h0000, 0, "R8 bnz loop");
    expect_out(16'h1B, 16'h00FD, 0, "R8 bnc taken");
    expect_out(16'h1C, 16'h00FD, 0, "R7 out");
    expect_out(16'h1D, 16'h00FD, 4, "R11 two-cycle");
    expect_out(16'h1E, 16'h00FD, 3, "R11 one-cycle");
  endtask

  // monitor: scoreboard, strobe width, stall freeze
  logic [PAW-1:0] prev_addr;
  logic prev_ce = 1'b0, prev_wr = 1'b0, prev_we = 1'b0, have_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
    end else if (!done) begin
      if (have_prev && !prev_ce)
        chk(pm_addr == prev_addr && io_wr == prev_wr && pm_we == prev_we,
            "R13", "outputs while stalled", 32'(pm_addr), 32'(prev_addr));
      if (have_prev && prev_ce && prev_wr)
        chk(!io_wr, "R12", "io_wr width", 32'(io_wr), 32'h0);
      if (have_prev && prev_ce && prev_we)
        chk(!pm_we, "R12", "pm_we width", 32'(pm_we), 32'h0);
      if (ce) begin
        since++;
        if (pm_we) begin
          chk(pm_addr == PAW'(8'h84), "R3", "store address", 32'(pm_addr), 32'h84);
          chk(pm_wdata == 16'h00FD, "R3", "store data", 32'(pm_wdata), 32'hFD);
        end
        if (io_wr) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected io write", 32'(io_addr), 32'h0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(io_addr == it.addr, it.req, "io address", 32'(io_addr), 32'(it.addr));
            chk(io_wdata == it.data, it.req, "io data", 32'(io_wdata), 32'(it.data));
            if (it.gap != 0)
              chk(since == it.gap, it.req, "cycle gap", 32'(since), 32'(it.gap));
            items_seen++;
            if (exp_q.size() == 0) done <= 1'b1;
          end
          since = 0;
        end
      end
      prev_addr <= pm_addr;
      prev_ce   <= ce;
      prev_wr   <= io_wr;
      prev_we   <= pm_we;
      have_prev <= 1'b1;
    end
  end

  // clock-enable driver: steady on the first pass, pseudo-random afterwards
  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    forever begin
      @(posedge clk);
      #2;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ce = (items_seen >= 15) ? (lf[0] | lf[1]) : 1'b1;
    end
  end

  initial begin
    bit finished;
    load_program();
    push_pass();
    push_pass();   // R10: empty pop returns to address 0 and reruns
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pm_addr == '0, "R1", "reset address", 32'(pm_addr), 32'h0);
    chk(!pm_we && !io_rd && !io_wr, "R1", "reset strobes",
        {29'h0, pm_we, io_rd, io_wr}, 32'h0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(pm_addr == '0, "R1", "first fetch address", 32'(pm_addr), 32'h0);
    @(negedge clk);
    chk(pm_addr == PAW'(8'h80), "R2", "operand field of first word", 32'(pm_addr), 32'h80);
    finished = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) begin finished = 1'b1; break; end
    end
    if (!finished) chk(1'b0, "R10", "watchdog expired", 32'(exp_q.size()), 32'h0);
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule